// File: doc/BRIEF.md
# Audio codec reset sequencer

This block controls the reset of an audio codec's digital core. Software drives a run bit: 1 means operate and 0 means hold in reset. The block does not apply that bit directly. It turns the bit into an internal reset whose two edges each lag the bit by a set number of sample periods. A one-cycle frame tick marks each sample period, and the block measures every delay by counting these ticks. While the internal reset is active, the block asserts the ADC and DAC power-down enables and holds the serial data output low. The block has no output that clears configuration state, so configuration registers keep their contents through a reset.

After the internal reset is released, the ADC runs an initialization window of fixed length. A busy flag is high for the length of this window. The ADC sample stream passes through the block on a valid/ready pair. Valid and ready pass through combinationally, so back-pressure from the consumer reaches the producer in the same cycle. No sample is stored and none is dropped. Until initialization has completed, the data word that goes out is forced to zero.

Ticks may stop completely while the block is in reset. The block then holds its state until ticks return.

Top module: `crst_seq`

## Requirements
- R1: While `rst_n` is sampled low, and on the cycles after it returns high until a tick-counted transition happens, the outputs are as follows: `int_rst`=1, `adc_init_busy`=0 and `op_normal`=0. All delay counters are cleared during this reset.
- R2: Counting starts with the clock edge after the one that samples `sw_run` going to 0. `int_rst` goes to 1 in the cycle after the 5th tick counted from that edge. It is still 0 after the 4th tick.
- R3: Counting starts with the clock edge after the one that samples `sw_run` going to 1. `int_rst` goes to 0 in the cycle after the 2nd tick counted from that edge. It is still 1 after the 1st tick.
- R4: Whenever `int_rst`=1, the outputs `dac_pd`, `adc_pd` and `sdto_force_low` are all 1.
- R5: `adc_out_data` is all zeros whenever `op_normal`=0. This includes every cycle with `int_rst`=1 and every cycle of initialization.
- R6: `adc_init_busy` goes to 1 in the same cycle that `int_rst` falls. It goes back to 0 during the clock cycle in which the 516th tick of initialization is present. `op_normal` goes to 1 in the cycle after that. From then on, `adc_out_data` equals `adc_in_data`.
- R7: If no ticks arrive, the reset state is held indefinitely, whatever the value of `sw_run`. Counting resumes when ticks return.
- R8: If `sw_run` returns to its earlier level before a pending delay has expired, the pending transition is cancelled. A later change then waits the full delay again, counted from zero.
- R9: If `sw_run` goes to 0 during initialization, initialization is aborted. `adc_init_busy` drops, and the block follows the R2 assert delay. After the next release, initialization runs its full 516 ticks again.
- R10: `adc_out_valid` equals `adc_in_valid` and `adc_in_ready` equals `adc_out_ready` in every cycle, whatever the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| fs_tick | input | 1 | One-cycle pulse per sample period |
| sw_run | input | 1 | Software run bit (0 requests reset) |
| adc_in_valid | input | 1 | ADC sample valid from converter |
| adc_in_ready | output | 1 | Ready toward converter |
| adc_in_data | input | W | ADC sample word |
| adc_out_valid | output | 1 | Gated sample valid |
| adc_out_ready | input | 1 | Ready from consumer |
| adc_out_data | output | W | Gated sample word, zero until normal |
| int_rst | output | 1 | Delayed internal reset, active high |
| adc_init_busy | output | 1 | ADC initialization window running |
| op_normal | output | 1 | Initialization completed, normal operation |
| sdto_force_low | output | 1 | Forces serial data output low |
| dac_pd | output | 1 | DAC power-down enable |
| adc_pd | output | 1 | ADC power-down enable |

## Verification
The bench builds the block with its default values. These are an assert delay of 5 ticks, a release delay of 2 ticks, an initialization of 516 ticks and a 16-bit sample word. The bench divides the clock by 4 to make the tick. With these values the 10-bit counter reaches its real terminal count. The boundary of the 515th and 516th initialization tick is therefore tested exactly. Each initialization costs about 2,000 cycles, which leaves room for repeated releases, aborts and cancellations.

// File: rtl/crst_pkg.sv
package crst_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_AWAIT = 3'd1,
    ST_RESET = 3'd2,
    ST_RWAIT = 3'd3,
    ST_INIT  = 3'd4
  } crst_state_e;

  function automatic int crst_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/crst_tick_cnt.sv
module crst_tick_cnt #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;

  assign hit = en && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (en)       cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/crst_fsm.sv
module crst_fsm
  import crst_pkg::*;
#(
  parameter int ASSERT_TICKS  = 5,
  parameter int RELEASE_TICKS = 2,
  parameter int INIT_TICKS    = 516,
  parameter int CW            = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_tick,
  input  logic          sw_run,
  input  logic          hit,
  output logic          cnt_clr,
  output logic          cnt_en,
  output logic [CW-1:0] limit,
  output logic          int_rst,
  output logic          busy,
  output logic          init_ok
);
  localparam logic [CW-1:0] LIM_ASSERT  = CW'(ASSERT_TICKS);
  localparam logic [CW-1:0] LIM_RELEASE = CW'(RELEASE_TICKS);
  localparam logic [CW-1:0] LIM_INIT    = CW'(INIT_TICKS);

  crst_state_e state, nxt;
  logic        ok_q, ok_d;

  always_comb begin
    case (state)
      ST_AWAIT: limit = LIM_ASSERT;
      ST_RWAIT: limit = LIM_RELEASE;
      ST_INIT:  limit = LIM_INIT;
      default:  limit = '0;
    endcase
  end

  assign cnt_en = fs_tick &&
                  (state == ST_AWAIT || state == ST_RWAIT || state == ST_INIT);

  always_comb begin
    nxt  = state;
    ok_d = ok_q;
    case (state)
      ST_RUN: begin
        if (!sw_run) nxt = ST_AWAIT;
      end
      ST_AWAIT: begin
        if (sw_run) begin
          nxt = ok_q ? ST_RUN : ST_INIT;
        end else if (hit) begin
          nxt  = ST_RESET;
          ok_d = 1'b0;
        end
      end
      ST_RESET: begin
        if (sw_run) nxt = ST_RWAIT;
      end
      ST_RWAIT: begin
        if (!sw_run)  nxt = ST_RESET;
        else if (hit) nxt = ST_INIT;
      end
      ST_INIT: begin
        if (!sw_run) begin
          nxt = ST_AWAIT;
        end else if (hit) begin
          nxt  = ST_RUN;
          ok_d = 1'b1;
        end
      end
      default: begin
        nxt  = ST_RESET;
        ok_d = 1'b0;
      end
    endcase
  end

  assign cnt_clr = (nxt != state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_RESET;
      ok_q  <= 1'b0;
    end else begin
      state <= nxt;
      ok_q  <= ok_d;
    end
  end

  assign int_rst = (state == ST_RESET) || (state == ST_RWAIT);
  assign busy    = (state == ST_INIT) && !hit;
  assign init_ok = ok_q;
endmodule

// File: rtl/crst_adc_gate.sv
module crst_adc_gate #(
  parameter int W = 16
) (
  input  logic         pass,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out_data[i] = in_data[i] & pass;
  end
endmodule

// File: rtl/crst_seq.sv
module crst_seq
  import crst_pkg::*;
#(
  parameter int W             = 16,
  parameter int ASSERT_TICKS  = 5,
  parameter int RELEASE_TICKS = 2,
  parameter int INIT_TICKS    = 516
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fs_tick,
  input  logic         sw_run,
  input  logic         adc_in_valid,
  output logic         adc_in_ready,
  input  logic [W-1:0] adc_in_data,
  output logic         adc_out_valid,
  input  logic         adc_out_ready,
  output logic [W-1:0] adc_out_data,
  output logic         int_rst,
  output logic         adc_init_busy,
  output logic         op_normal,
  output logic         sdto_force_low,
  output logic         dac_pd,
  output logic         adc_pd
);
  localparam int MAXT = crst_max3(ASSERT_TICKS, RELEASE_TICKS, INIT_TICKS);
  localparam int CW   = $clog2(MAXT + 1);

  logic          cnt_clr, cnt_en, hit;
  logic [CW-1:0] limit;
  logic          rst_i, ok_i;

  crst_tick_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .limit (limit),
    .hit   (hit)
  );

  crst_fsm #(
    .ASSERT_TICKS  (ASSERT_TICKS),
    .RELEASE_TICKS (RELEASE_TICKS),
    .INIT_TICKS    (INIT_TICKS),
    .CW            (CW)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs_tick (fs_tick),
    .sw_run  (sw_run),
    .hit     (hit),
    .cnt_clr (cnt_clr),
    .cnt_en  (cnt_en),
    .limit   (limit),
    .int_rst (rst_i),
    .busy    (adc_init_busy),
    .init_ok (ok_i)
  );

  crst_adc_gate #(.W(W)) u_gate (
    .pass      (ok_i),
    .in_valid  (adc_in_valid),
    .in_ready  (adc_in_ready),
    .in_data   (adc_in_data),
    .out_valid (adc_out_valid),
    .out_ready (adc_out_ready),
    .out_data  (adc_out_data)
  );

  assign int_rst        = rst_i;
  assign op_normal      = ok_i;
  assign sdto_force_low = rst_i;
  assign dac_pd         = rst_i;
  assign adc_pd         = rst_i;
endmodule

// File: rtl/crst_seq_chk.sv
module crst_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fs_tick,
  input logic         adc_in_valid,
  input logic         adc_in_ready,
  input logic         adc_out_valid,
  input logic         adc_out_ready,
  input logic [W-1:0] adc_out_data,
  input logic         int_rst,
  input logic         adc_init_busy,
  input logic         op_normal,
  input logic         sdto_force_low,
  input logic         dac_pd,
  input logic         adc_pd
);
  AST_PD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> (dac_pd && adc_pd && sdto_force_low)); // R4

  AST_ZERO_NOT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rst || adc_init_busy) |-> (adc_out_data == '0)); // R5

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst) |-> $past(fs_tick)); // R2

  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst) |-> ($past(fs_tick) && adc_init_busy)); // R3

  AST_NORMAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    op_normal |-> (!adc_init_busy && !int_rst)); // R6

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fs_tick) && $past(int_rst)) |-> int_rst); // R7

  AST_STREAM_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_out_valid == adc_in_valid) && (adc_in_ready == adc_out_ready)); // R10
endmodule

bind crst_seq crst_seq_chk #(.W(W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fs_tick        (fs_tick),
  .adc_in_valid   (adc_in_valid),
  .adc_in_ready   (adc_in_ready),
  .adc_out_valid  (adc_out_valid),
  .adc_out_ready  (adc_out_ready),
  .adc_out_data   (adc_out_data),
  .int_rst        (int_rst),
  .adc_init_busy  (adc_init_busy),
  .op_normal      (op_normal),
  .sdto_force_low (sdto_force_low),
  .dac_pd         (dac_pd),
  .adc_pd         (adc_pd)
);

// File: tb/test_crst_seq.sv
`timescale 1ns/1ps
module test_crst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int TDIV       = 4;
  localparam int INIT_N     = 516;
  localparam logic [W-1:0] SAMPLE = 16'hA5C3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fs_tick = 1'b0;
  logic         sw_run = 1'b0;
  logic         adc_in_valid = 1'b1;
  logic         adc_in_ready;
  logic [W-1:0] adc_in_data = SAMPLE;
  logic         adc_out_valid;
  logic         adc_out_ready = 1'b1;
  logic [W-1:0] adc_out_data;
  logic         int_rst, adc_init_busy, op_normal, sdto_force_low, dac_pd, adc_pd;

  logic         tick_on = 1'b1;
  int           div = 0;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done = 0;

  crst_seq #(.W(W)) i_crst_seq (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .sw_run(sw_run),
    .adc_in_valid(adc_in_valid), .adc_in_ready(adc_in_ready),
    .adc_in_data(adc_in_data), .adc_out_valid(adc_out_valid),
    .adc_out_ready(adc_out_ready), .adc_out_data(adc_out_data),
    .int_rst(int_rst), .adc_init_busy(adc_init_busy), .op_normal(op_normal),
    .sdto_force_low(sdto_force_low), .dac_pd(dac_pd), .adc_pd(adc_pd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!tick_on) begin
      fs_tick <= 1'b0;
      div     <= 0;
    end else begin
      fs_tick <= (div == TDIV-1);
      div     <= (div == TDIV-1) ? 0 : div + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // advance past the next clock edge that samples a tick, then settle mid-cycle
  task automatic tick_edge();
    do @(posedge clk); while (!fs_tick);
    @(negedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_edge();
  endtask

  task automatic set_sw(input logic v);
    sw_run = v;
    @(posedge clk);
  endtask

  task automatic release_to_init();
    set_sw(1'b1);
    tick_edge();
    chk("R3 still reset after 1 tick", int_rst, 1);
    tick_edge();
    chk("R3 released after 2 ticks", int_rst, 0);
    chk("R6 busy at release", adc_init_busy, 1);
  endtask

  task automatic finish_init();
    ticks(INIT_N - 1);
    chk("R6 busy after 515 ticks", adc_init_busy, 1);
    chk("R5 zero during init", adc_out_data, 0);
    do begin @(negedge clk); #1; end while (!fs_tick);
    chk("R6 busy low on 516th tick", adc_init_busy, 0);
    chk("R6 not yet normal", op_normal, 0);
    @(negedge clk); #1;
    chk("R6 normal", op_normal, 1);
    chk("R6 data passes", adc_out_data, SAMPLE);
  endtask

  task automatic assert_path();
    set_sw(1'b0);
    ticks(4);
    chk("R2 no reset after 4 ticks", int_rst, 0);
    tick_edge();
    chk("R2 reset after 5 ticks", int_rst, 1);
    chk("R4 dac pd", dac_pd, 1);
    chk("R4 adc pd", adc_pd, 1);
    chk("R4 sdto low", sdto_force_low, 1);
    chk("R5 zero in reset", adc_out_data, 0);
    chk("R2 normal cleared", op_normal, 0);
  endtask

  task automatic t_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 int_rst", int_rst, 1);
    chk("R1 busy", adc_init_busy, 0);
    chk("R1 normal", op_normal, 0);
    chk("R4 pd at reset", {dac_pd, adc_pd, sdto_force_low}, 3'b111);
    chk("R5 zero at reset", adc_out_data, 0);
  endtask

  task automatic t_stream();
    adc_out_ready = 1'b0; #1;
    chk("R10 ready back-pressure", adc_in_ready, 0);
    adc_in_valid = 1'b0; #1;
    chk("R10 valid low", adc_out_valid, 0);
    adc_out_ready = 1'b1; adc_in_valid = 1'b1; #1;
    chk("R10 ready/valid high", {adc_in_ready, adc_out_valid}, 2'b11);
  endtask

  task automatic t_cancel_assert();
    set_sw(1'b0);
    ticks(3);
    set_sw(1'b1);
    ticks(10);
    chk("R8 assert cancelled", int_rst, 0);
    chk("R8 still normal", op_normal, 1);
    assert_path();
  endtask

  task automatic t_cancel_release();
    set_sw(1'b1);
    tick_edge();
    set_sw(1'b0);
    ticks(6);
    chk("R8 release cancelled", int_rst, 1);
    chk("R8 no busy", adc_init_busy, 0);
    release_to_init();
  endtask

  task automatic t_abort_init();
    ticks(100);
    set_sw(1'b0);
    @(negedge clk); #1;
    chk("R9 busy dropped", adc_init_busy, 0);
    chk("R9 zero data", adc_out_data, 0);
    ticks(4);
    chk("R9 no reset after 4", int_rst, 0);
    tick_edge();
    chk("R9 reset after abort", int_rst, 1);
    release_to_init();
    finish_init();
  endtask

  task automatic t_no_ticks();
    tick_on = 1'b0;
    repeat (300) @(negedge clk); #1;
    chk("R7 hold low bit", int_rst, 1);
    sw_run = 1'b1;
    repeat (300) @(negedge clk); #1;
    chk("R7 hold without ticks", int_rst, 1);
    chk("R7 no busy", adc_init_busy, 0);
    tick_on = 1'b1;
    tick_edge();
    chk("R7 one tick after resume", int_rst, 1);
    tick_edge();
    chk("R7 released after resume", int_rst, 0);
    finish_init();
  endtask

  task automatic t_hw_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); #1;
    chk("R1 mid-run int_rst", int_rst, 1);
    chk("R1 mid-run normal", op_normal, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    release_to_init();
    finish_init();
    t_stream();
    assert_path();
    release_to_init();
    finish_init();
    t_cancel_assert();
    t_cancel_release();
    t_abort_init();
    assert_path();
    t_no_ticks();
    t_hw_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule